// File: doc/BRIEF.md
# Three-Phase Dual-Rail Register Stage

This block is a cycle-accurate behavioural model of a master-slave register meant for a dual-rail domino logic style in which every rail pair runs through three phases each cycle: both rails charged high, the rail picked by the data pulled low, then the remaining rail pulled low too. Each bit travels as an independent true/false rail pair. One fast base clock drives a step sequencer, and the register clock and every phase control are derived from it. An input half-stage evaluates while the register clock is low. Gating logic feeds its result into a set/reset latch and holds both latch inputs inactive outside that window. An output half-stage evaluates from the latch while the register clock is high.

A register period lasts `2*HALF` base-clock steps, numbered 0 to `2*HALF-1` from the end of reset. During steps 0 to HALF-1 the register clock is low and the input rails are sampled on each base-clock edge. During the remaining steps the register clock is high and the output pair carries the captured value. The block also raises an error pulse when the incoming rails break the protocol: rails that are not both low when the evaluate window opens, or a window that closes with no evaluation.

Top module: `tdr_reg_stage`

## Requirements
- R1: While `rst_n` is low, every `dout_t` and `dout_f` bit is 1, `rail_err` is 0 and `reg_clk` is 0, and the latch is cleared to 0. Until the first discharge, the output pair stays at 1/1.
- R2: `reg_clk` is 0 for steps 0 to HALF-1 and 1 for steps HALF to 2*HALF-1 of every period.
- R3: At step HALF (the first step with `reg_clk` high), every output bit shows 1/1 (charged). From the second period on, every output bit shows 0/0 (discharged) during steps 0 to HALF-1.
- R4: An input rail pair is evaluated on the base-clock edges that end steps 0 to HALF-1. The first edge that sees exactly one rail high captures the value (`din_t` high means 1). From step HALF+1 to the end of the period the output shows `dout_t`=value and `dout_f`=~value.
- R5: After a bit has evaluated, a later rise of its other rail within the same window does not change the captured value.
- R6: An edge that sees both rails of a bit high does not evaluate that bit.
- R7: If a bit is not evaluated within the window, the latch keeps its previous value. That value appears on the output, and `rail_err` is 1 during step HALF.
- R8: If any input rail is high on the edge ending step 0, `rail_err` is 1 during step 1, and the bit is still evaluated by R4.
- R9: Input rails during steps HALF to 2*HALF-1 have no effect on the latch or the output.
- R10: The two latch inputs of a bit are never active (low) together. Both stay inactive whenever `reg_clk` is high.
- R11: Each bit is captured, held and error-checked independently of the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, 2*HALF steps per register period |
| rst_n | input | 1 | Synchronous active-low reset |
| din_t | input | WIDTH | True rails of the incoming pairs |
| din_f | input | WIDTH | False rails of the incoming pairs |
| dout_t | output | WIDTH | True rails of the outgoing pairs |
| dout_f | output | WIDTH | False rails of the outgoing pairs |
| reg_clk | output | 1 | Derived register clock |
| rail_err | output | 1 | Pulse on a rail protocol violation of any bit |

## Verification
The hardest cases to reach are a bit that evaluates and then has its opposite rail rise later in the same window, and a window in which both rails rise on the same edge, leaving the bit unevaluated. Neither shows up with well-behaved upstream logic. The bench builds each period as a per-bit script of rail waveforms (late rise, early rise, glitching second rail, simultaneous rise, no rise) and mixes these scripts across bits in the same period. It also drives random junk on the rails outside the window. The expected values come from a scan of the driven waveform for the first single-rail edge.

// File: rtl/tdr_pkg.sv
// Shared types for the three-phase dual-rail register stage.
// Assumes one control bundle per base-clock step, decoded from the step count.
package tdr_pkg;

    // One-step strobes for both half-stages; each is high on the edge that ends the step.
    typedef struct packed {
        logic a_eval;   // input half-stage evaluates on this edge
        logic a_first;  // first edge of the input evaluate window
        logic a_last;   // last edge of the input evaluate window
        logic a_dis;    // input half-stage discharges its remaining rail
        logic a_pre;    // input half-stage charges both rails
        logic b_pre;    // output half-stage charges both rails
        logic b_eval;   // output half-stage evaluates from the latch
        logic b_dis;    // output half-stage discharges both rails
    } tdr_ctl_t;

endpackage

// File: rtl/tdr_phase_seq.sv
// Step sequencer: counts base-clock steps through one register period and
// decodes the register clock plus all phase strobes of both half-stages.
// Assumes HALF >= 2 so that the strobes of each half-stage fall on distinct steps.
module tdr_phase_seq
    import tdr_pkg::*;
#(
    parameter int HALF = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    output tdr_ctl_t ctl,
    output logic     reg_clk
);
    localparam int PERIOD = 2 * HALF;
    localparam int CW     = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST_STEP = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HALF_STEP = CW'(HALF);
    localparam logic [CW-1:0] EVAL_END  = CW'(HALF - 1);

    logic [CW-1:0] step_q;

    // Purpose: advance the step counter, wrapping at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)                  step_q <= '0;
        else if (step_q == LAST_STEP) step_q <= '0;
        else                          step_q <= step_q + 1'b1;
    end

    // Purpose: decode the phase strobes from the current step.
    always_comb begin
        ctl.a_eval  = (step_q < HALF_STEP);
        ctl.a_first = (step_q == '0);
        ctl.a_last  = (step_q == EVAL_END);
        ctl.a_dis   = (step_q == HALF_STEP);
        ctl.a_pre   = (step_q == LAST_STEP);
        ctl.b_pre   = (step_q == EVAL_END);
        ctl.b_eval  = (step_q == HALF_STEP);
        ctl.b_dis   = (step_q == LAST_STEP);
    end

    assign reg_clk = (step_q >= HALF_STEP);

endmodule

// File: rtl/tdr_in_bit.sv
// Input half-stage of one bit with its gated set/reset latch.
// The two dynamic nodes start charged. The first single-rail rise in the window
// discharges one node and locks the other. Gating holds the latch inputs
// inactive outside the window. Assumes the strobes come from tdr_phase_seq.
module tdr_in_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_en,
    input  logic first_en,
    input  logic last_en,
    input  logic dis_en,
    input  logic pre_en,
    input  logic rail_t,
    input  logic rail_f,
    output logic set_n,
    output logic clr_n,
    output logic q,
    output logic err
);
    logic node_t, node_f;
    logic live, rise_t, rise_f, nx_t, nx_f;

    // Purpose: next node values in evaluate; only a lone rising rail discharges a live pair.
    always_comb begin
        live   = node_t & node_f;
        rise_t = rail_t & ~rail_f;
        rise_f = rail_f & ~rail_t;
        nx_t   = node_t & ~(live & rise_t);
        nx_f   = node_f & ~(live & rise_f);
    end

    // Latch inputs, forced inactive outside the evaluate window.
    assign set_n = nx_t | ~eval_en;
    assign clr_n = nx_f | ~eval_en;

    // Purpose: step the dynamic nodes through evaluate, discharge and charge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_t <= 1'b1;
            node_f <= 1'b1;
        end else if (eval_en) begin
            node_t <= nx_t;
            node_f <= nx_f;
        end else if (dis_en) begin
            node_t <= 1'b0;
            node_f <= 1'b0;
        end else if (pre_en) begin
            node_t <= 1'b1;
            node_f <= 1'b1;
        end
    end

    // Purpose: set/reset latch that holds the captured value for the output half-stage.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (!set_n) q <= 1'b1;
        else if (!clr_n) q <= 1'b0;
    end

    // Purpose: flag a pair that is not idle at window start or unevaluated at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (first_en & (rail_t | rail_f)) | (last_en & nx_t & nx_f);
    end

endmodule

// File: rtl/tdr_out_stage.sv
// Output half-stage for all bits: charges both rails, evaluates from the latch
// values (a 1 pulls the false rail low), then discharges both rails.
// Assumes the latch is stable on the evaluate edge.
module tdr_out_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_en,
    input  logic             eval_en,
    input  logic             dis_en,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] dout_t,
    output logic [WIDTH-1:0] dout_f
);
    // Purpose: sequence the outgoing rail pairs through their three phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_t <= '1;
            dout_f <= '1;
        end else if (pre_en) begin
            dout_t <= '1;
            dout_f <= '1;
        end else if (eval_en) begin
            dout_t <= q;
            dout_f <= ~q;
        end else if (dis_en) begin
            dout_t <= '0;
            dout_f <= '0;
        end
    end

endmodule

// File: rtl/tdr_reg_stage.sv
// Three-phase dual-rail master-slave register.
// The sequencer drives one input half-stage per bit and a shared output half-stage.
// Assumes the upstream rails are both low at window start and that one rail then rises.
module tdr_reg_stage
    import tdr_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int HALF  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_t,
    input  logic [WIDTH-1:0] din_f,
    output logic [WIDTH-1:0] dout_t,
    output logic [WIDTH-1:0] dout_f,
    output logic             reg_clk,
    output logic             rail_err
);
    tdr_ctl_t         ctl;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] latch_set_n;
    logic [WIDTH-1:0] latch_clr_n;
    logic [WIDTH-1:0] bit_err;

    tdr_phase_seq #(.HALF(HALF)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .reg_clk (reg_clk)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        tdr_in_bit i_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .eval_en  (ctl.a_eval),
            .first_en (ctl.a_first),
            .last_en  (ctl.a_last),
            .dis_en   (ctl.a_dis),
            .pre_en   (ctl.a_pre),
            .rail_t   (din_t[b]),
            .rail_f   (din_f[b]),
            .set_n    (latch_set_n[b]),
            .clr_n    (latch_clr_n[b]),
            .q        (latch_q[b]),
            .err      (bit_err[b])
        );
    end

    tdr_out_stage #(.WIDTH(WIDTH)) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_en  (ctl.b_pre),
        .eval_en (ctl.b_eval),
        .dis_en  (ctl.b_dis),
        .q       (latch_q),
        .dout_t  (dout_t),
        .dout_f  (dout_f)
    );

    assign rail_err = |bit_err;

endmodule

// File: rtl/tdr_reg_stage_chk.sv
// Protocol checker for tdr_reg_stage, attached by bind.
// Assumes HALF >= 2, so the first high step of reg_clk is the output charge step.
module tdr_reg_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_clk,
    input logic [WIDTH-1:0] dout_t,
    input logic [WIDTH-1:0] dout_f,
    input logic             rail_err,
    input logic [WIDTH-1:0] set_n,
    input logic [WIDTH-1:0] clr_n
);
    AST_RESET_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&dout_t && &dout_f)); // R1
    AST_CHARGE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_clk) |-> (&dout_t && &dout_f)); // R3
    AST_DISCHARGE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_clk) |-> (~|dout_t && ~|dout_f)); // R3
    AST_EVAL_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_clk && !$rose(reg_clk)) |-> &(dout_t ^ dout_f)); // R4
    AST_ERR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_err && reg_clk) |-> $rose(reg_clk)); // R7
    AST_NO_ILLEGAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ~|(~set_n & ~clr_n)); // R10
    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clk |-> (&set_n && &clr_n)); // R9

endmodule

bind tdr_reg_stage tdr_reg_stage_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_clk  (reg_clk),
    .dout_t   (dout_t),
    .dout_f   (dout_f),
    .rail_err (rail_err),
    .set_n    (latch_set_n),
    .clr_n    (latch_clr_n)
);

// File: tb/test_tdr_reg_stage.sv
`timescale 1ns/1ps
module test_tdr_reg_stage;
    localparam int W     = 4;
    localparam int HALF  = 3;
    localparam int STEPS = 2 * HALF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din_t = '0;
    logic [W-1:0] din_f = '0;
    logic [W-1:0] dout_t, dout_f;
    logic         reg_clk, rail_err;

    always #2 clk = ~clk;   // 250 MHz

    tdr_reg_stage #(.WIDTH(W), .HALF(HALF)) i_tdr_reg_stage (
        .clk(clk), .rst_n(rst_n), .din_t(din_t), .din_f(din_f),
        .dout_t(dout_t), .dout_f(dout_f), .reg_clk(reg_clk), .rail_err(rail_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    int period_no = 0;
    string cur_tag;

    // Per-bit script kinds: 0 rise at step 1, 1 rise at step 2, 2 rise then glitch (R5),
    // 3 no rise (R7), 4 both rails together (R6), 5 rail already high at step 0 (R8).
    int           kind [W];
    logic [W-1:0] val;
    bit           junk;
    logic [W-1:0] drv_t [STEPS];
    logic [W-1:0] drv_f [STEPS];
    logic [W-1:0] model_q = '0;
    logic [W-1:0] exp_q;
    bit           exp_start, exp_end;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s period %0d: actual %h expected %h", req, what, period_no, act, exp);
        end
    endtask

    // Build the rail waveforms of one period from the per-bit scripts.
    task automatic build_drive();
        for (int k = 0; k < STEPS; k++) begin
            drv_t[k] = '0;
            drv_f[k] = '0;
            for (int b = 0; b < W; b++) begin
                logic s, o;
                s = 1'b0; o = 1'b0;
                if (k < HALF) begin
                    case (kind[b])
                        0: s = (k >= 1);
                        1: s = (k == 2);
                        2: begin s = (k >= 1); o = (k == 2); end
                        4: begin s = (k >= 1); o = (k >= 1); end
                        5: s = 1'b1;
                        default: ;
                    endcase
                end else if (junk) begin
                    s = 1'($urandom_range(0, 1));
                    o = 1'($urandom_range(0, 1));
                end
                drv_t[k][b] = val[b] ? s : o;
                drv_f[k][b] = val[b] ? o : s;
            end
        end
    endtask

    // Reference model: the first edge with exactly one rail high captures; else hold.
    function automatic void compute_expect();
        exp_start = 1'b0;
        exp_end   = 1'b0;
        for (int b = 0; b < W; b++) begin
            bit found;
            found = 1'b0;
            exp_start |= drv_t[0][b] | drv_f[0][b];
            exp_q[b] = model_q[b];
            for (int k = 0; k < HALF; k++) begin
                if (!found && (drv_t[k][b] ^ drv_f[k][b])) begin
                    found = 1'b1;
                    exp_q[b] = drv_t[k][b];
                end
            end
            if (!found) exp_end = 1'b1;
        end
    endfunction

    task automatic run_period();
        build_drive();
        compute_expect();
        for (int k = 0; k < STEPS; k++) begin
            @(negedge clk);
            check("R2", "reg_clk", 32'(reg_clk), 32'(k >= HALF));
            if (k == 1)         check("R8", "rail_err", 32'(rail_err), 32'(exp_start));
            else if (k == HALF) check("R7", "rail_err", 32'(rail_err), 32'(exp_end));
            else                check("R7 R8", "rail_err", 32'(rail_err), 32'd0);
            if (k < HALF) begin
                if (period_no == 0) check("R1", "dout", {dout_t, dout_f}, {{W{1'b1}}, {W{1'b1}}});
                else                check("R3", "dout", {dout_t, dout_f}, 32'd0);
            end else if (k == HALF) begin
                check("R3", "dout", {dout_t, dout_f}, {{W{1'b1}}, {W{1'b1}}});
            end else begin
                check(cur_tag, "dout", {dout_t, dout_f}, {exp_q, ~exp_q});
            end
            din_t = drv_t[k];
            din_f = drv_f[k];
        end
        model_q = exp_q;
        period_no++;
    endtask

    task automatic set_all(input int kd, input string tag);
        for (int b = 0; b < W; b++) kind[b] = kd;
        val  = W'($urandom);
        junk = 1'b0;
        cur_tag = tag;
        run_period();
    endtask

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset dout", {dout_t, dout_f}, {{W{1'b1}}, {W{1'b1}}});
        check("R1", "reset rail_err", 32'(rail_err), 32'd0);
        check("R1", "reset reg_clk", 32'(reg_clk), 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        set_all(3, "R1 R7");     // no evaluation: the cleared latch value shows
        set_all(0, "R4");
        set_all(1, "R4");
        set_all(2, "R5");
        set_all(4, "R6 R7");
        set_all(5, "R8 R4");
        // R11: mixed scripts across bits in one period
        kind[0] = 0; kind[1] = 2; kind[2] = 3; kind[3] = 5;
        val = 4'b1010; junk = 1'b1; cur_tag = "R11 R9";
        run_period();

        for (int p = 0; p < 250; p++) begin
            for (int b = 0; b < W; b++) begin
                int r;
                r = int'($urandom_range(0, 9));
                if (r < 8)       kind[b] = r % 3;
                else if (r == 8) kind[b] = 3 + int'($urandom_range(0, 2));
                else             kind[b] = 0;
            end
            val  = W'($urandom);
            junk = 1'($urandom_range(0, 1));
            cur_tag = "R4 R9 R11";
            run_period();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule